// File: doc/BRIEF.md
# System Watchdog Timer with Bus-Transaction Monitor

This block is a software watchdog for a processor subsystem. Software sets a 16-bit timeout and the expiry action in a control register, then enables the timer. While enabled, a down-counter steps once per clock, or once per prescale period when the prescale bit is set. Software keeps the timer from expiring by writing a fixed pair of magic words to a 16-bit service register, in a fixed order. When the counter runs out, the block either pulses a reset request for one cycle or raises a sticky interrupt. It then reloads and keeps counting. The current count can be read back at any time. A freeze option halts counting while an external debug-freeze input is high.

The same control register also programs a bus-transaction monitor. Once armed, it measures the time from each transfer start to its acknowledge. If the acknowledge does not arrive within a programmed number of 8-clock units, it flags a bus error for one cycle. The reset-generation circuitry that acts on the reset request lives outside this block.

Top module: `sys_watchdog`

## Requirements
- R1: After reset the control register reads 0, the count register reads 0, and `rst_req`, `irq` and `bus_err` are low.
- R2: Register offsets are 0x4 (control), 0x8 (count) and 0xE (service, data in `reg_wdata[15:0]`). The control fields are: bits 31:16 timeout, bits 15:8 bus limit, bit 7 bus-monitor enable, bit 3 freeze enable, bit 2 watchdog enable, bit 1 action (1 = reset, 0 = interrupt), bit 0 prescale enable. Control reads return the written value with bits 6:4 as 0. The count register reads the counter in bits 15:0, and writes to it are ignored. Any other offset reads 0.
- R3: A write to the control register loads the counter with the new timeout field and restarts the prescaler.
- R4: When enabled with prescale off, the counter decreases once per clock. The Nth clock after the load is the expiry, and at that clock the counter reloads N.
- R5: With prescale on, the counter decreases once every PRESCALE clocks (default 2048).
- R6: Writing 0x556C and then 0xAA39 to the service register reloads the counter from the timeout field.
- R7: A service write of any other value after 0x556C cancels the sequence, so a later 0xAA39 does not reload. A lone 0xAA39 has no effect.
- R8: With action = 1, expiry drives `rst_req` high for exactly one cycle and leaves `irq` unchanged.
- R9: With action = 0, expiry sets `irq`. It stays set through further expiries until a completed service sequence clears it.
- R10: The counter holds while both the freeze bit and `dbg_freeze` are high. Either one alone does not stop counting.
- R11: With the enable bit clear, the counter holds and no expiry occurs.
- R12: With the monitor enabled and limit L > 0, `bus_err` pulses for one cycle L*8 clocks after the clock that sampled `bus_start`, unless `bus_ack` is sampled first. A limit of 0, or a disabled monitor, never flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| dbg_freeze | input | 1 | Debug-freeze request |
| bus_start | input | 1 | Bus transfer start, one cycle |
| bus_ack | input | 1 | Bus transfer acknowledge |
| rst_req | output | 1 | One-cycle reset request on expiry |
| irq | output | 1 | Sticky watchdog interrupt |
| bus_err | output | 1 | One-cycle bus-timeout flag |

## Verification
The assertions assume that register writes last one cycle and that `bus_start` and `bus_ack` are single-cycle strobes, each sampled on a rising edge. They also assume that reset is held for at least one clock. The bench drives every input on the falling edge through tasks that raise a strobe for exactly one cycle. It keeps the watchdog disabled during the bus-monitor scenarios, so that expiry events do not overlap with bus-error checks.

// File: rtl/wdt_pkg.sv
// Package: register offsets, control field positions and service words
// shared by the watchdog block and its submodules.
package wdt_pkg;
    localparam int OFS_CTRL  = 4;
    localparam int OFS_COUNT = 8;
    localparam int OFS_SVC   = 14;

    localparam int B_PSC = 0;
    localparam int B_ACT = 1;
    localparam int B_EN  = 2;
    localparam int B_FRZ = 3;
    localparam int B_BME = 7;
    localparam int LIM_LO = 8;
    localparam int TMO_LO = 16;

    localparam logic [31:0] CTRL_MASK = 32'hFFFF_FF8F;
    localparam logic [15:0] SVC_KEY_A = 16'h556C;
    localparam logic [15:0] SVC_KEY_B = 16'hAA39;
endpackage

// File: rtl/wdt_tick_gen.sv
// Tick generator: emits one count-enable per clock, or one per PRESCALE
// clocks when prescaling is on. Assumes restart has priority over run.
module wdt_tick_gen #(
    parameter int PRESCALE = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic psc_en,
    output logic tick
);
    generate
        if (PRESCALE > 1) begin : g_div
            localparam int DW = $clog2(PRESCALE);
            localparam logic [DW-1:0] DMAX = DW'(PRESCALE - 1);
            logic [DW-1:0] div;

            // Advance the divider while the timer runs in prescaled mode.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) div <= '0;
                else if (run && psc_en) div <= (div == DMAX) ? '0 : div + 1'b1;
            end

            assign tick = run && (!psc_en || div == DMAX);
        end else begin : g_nodiv
            assign tick = run;
        end
    endgenerate
endmodule

// File: rtl/wdt_svc_seq.sv
// Service sequencer: detects the first key followed by the second key on
// consecutive service writes. Any other value drops the armed state.
module wdt_svc_seq
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_data,
    output logic        svc_ok
);
    logic armed;

    // Track whether the first key was the last service word written.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else if (svc_wr) armed <= (svc_data == SVC_KEY_A);
    end

    assign svc_ok = svc_wr && armed && (svc_data == SVC_KEY_B);

    // R7
    unarmed_no_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |-> $past(svc_wr) && $past(svc_data) == SVC_KEY_A);
endmodule

// File: rtl/wdt_bus_mon.sv
// Bus monitor: counts clocks from a transfer start until acknowledge and
// pulses bus_err when the programmed limit (in BM_UNIT clocks) is reached.
// Assumes start and ack are single-cycle strobes; start wins over ack.
module wdt_bus_mon #(
    parameter int LIM_W   = 8,
    parameter int BM_UNIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_en,
    input  logic [LIM_W-1:0] limit,
    input  logic             xfer_start,
    input  logic             xfer_ack,
    output logic             bus_err
);
    localparam int CW = LIM_W + $clog2(BM_UNIT) + 1;
    logic [CW-1:0] elapsed;
    logic [CW-1:0] lim_clks;
    logic          busy;
    logic          hit;

    assign lim_clks = CW'(limit) * CW'(BM_UNIT);
    assign hit = busy && (limit != '0) && (elapsed == lim_clks - 1'b1) && !xfer_ack;

    // Track one outstanding transfer and count its age.
    always_ff @(posedge clk) begin
        if (!rst_n || !mon_en) begin
            busy <= 1'b0;
            elapsed <= '0;
        end else if (xfer_start) begin
            busy <= 1'b1;
            elapsed <= '0;
        end else if (xfer_ack || hit) begin
            busy <= 1'b0;
        end else if (busy) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Register the timeout flag for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else bus_err <= hit && !xfer_start;
    end

    // R12
    bus_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);
    // R12
    bus_err_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(mon_en) && $past(limit) != '0);
endmodule

// File: rtl/sys_watchdog.sv
// System watchdog top: control/count/service registers, timeout counter,
// expiry action and the bus monitor. Assumes one-cycle register write
// strobes; reads are combinational from reg_addr.
module sys_watchdog
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int PRESCALE = 2048,
    parameter int BM_UNIT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dbg_freeze,
    input  logic              bus_start,
    input  logic              bus_ack,
    output logic              rst_req,
    output logic              irq,
    output logic              bus_err
);
    localparam int TW = 16;
    localparam int LW = 8;

    logic [31:0]   ctrl;
    logic [TW-1:0] cnt;
    logic          ctrl_wr, svc_wr, svc_ok;
    logic          load, tick, run, expire;
    logic [TW-1:0] tmo_field;

    assign ctrl_wr   = reg_wr && reg_addr == ADDR_W'(OFS_CTRL);
    assign svc_wr    = reg_wr && reg_addr == ADDR_W'(OFS_SVC);
    assign tmo_field = ctrl[TMO_LO +: TW];
    assign load      = ctrl_wr || svc_ok;
    assign run       = ctrl[B_EN] && !(ctrl[B_FRZ] && dbg_freeze);
    assign expire    = !load && tick && (cnt <= 16'd1);

    // Hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (ctrl_wr) ctrl <= reg_wdata & CTRL_MASK;
    end

    // Load, step down and reload the timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (ctrl_wr) cnt <= reg_wdata[TMO_LO +: TW];
        else if (svc_ok) cnt <= tmo_field;
        else if (expire) cnt <= tmo_field;
        else if (tick) cnt <= cnt - 1'b1;
    end

    // Drive the expiry action outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= expire && ctrl[B_ACT];
            if (svc_ok) irq <= 1'b0;
            else if (expire && !ctrl[B_ACT]) irq <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        if (reg_addr == ADDR_W'(OFS_CTRL)) reg_rdata = ctrl;
        else if (reg_addr == ADDR_W'(OFS_COUNT)) reg_rdata = {16'h0, cnt};
        else reg_rdata = '0;
    end

    wdt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(load),
        .psc_en(ctrl[B_PSC]), .tick(tick)
    );

    wdt_svc_seq u_svc (
        .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr),
        .svc_data(reg_wdata[15:0]), .svc_ok(svc_ok)
    );

    wdt_bus_mon #(.LIM_W(LW), .BM_UNIT(BM_UNIT)) u_bmon (
        .clk(clk), .rst_n(rst_n), .mon_en(ctrl[B_BME]),
        .limit(ctrl[LIM_LO +: LW]), .xfer_start(bus_start),
        .xfer_ack(bus_ack), .bus_err(bus_err)
    );

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[B_EN] && !load) |=> $stable(cnt));
    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[B_EN] && ctrl[B_FRZ] && dbg_freeze && !load) |=> $stable(cnt));
    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !svc_ok) |=> irq);
    // R6
    svc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && !ctrl_wr) |=> cnt == $past(tmo_field));
endmodule

// File: tb/sim_sys_watchdog.sv
module sim_sys_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int PSC = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        dbg_freeze = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_ack = 1'b0;
    logic        rst_req, irq, bus_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_watchdog #(.ADDR_W(4), .PRESCALE(PSC), .BM_UNIT(8)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_freeze(dbg_freeze),
        .bus_start(bus_start), .bus_ack(bus_ack), .rst_req(rst_req),
        .irq(irq), .bus_err(bus_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic service();
        wr(4'hE, 32'h556C);
        wr(4'hE, 32'hAA39);
    endtask

    function automatic logic [31:0] mk(input int tmo, input int lim, input logic bme,
                                       input logic frz, input logic en, input logic act,
                                       input logic psc);
        return {16'(tmo), 8'(lim), bme, 3'b000, frz, en, act, psc};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(4'h4, d); check("R1 ctrl", d, 0);
        rd(4'h8, d); check("R1 count", d, 0);
        check("R1 outs", {29'h0, rst_req, irq, bus_err}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(4'h4, 32'h1234_A5F2);
        rd(4'h4, d); check("R2 ctrl readback", d, 32'h1234_A582);
        rd(4'h8, d); check("R2 count", d, 32'h1234);
        wr(4'h8, 32'h0000_0077);
        rd(4'h8, d); check("R2 count write ignored", d, 32'h1234);
        rd(4'h0, d); check("R2 unmapped", d, 0);
        rd(4'hE, d); check("R2 service reads zero", d, 0);
        wr(4'h4, 0);
    endtask

    task automatic t_count_irq();
        logic [31:0] d;
        wr(4'h4, mk(5, 0, 0, 0, 1, 0, 0));
        rd(4'h8, d); check("R3 load", d, 5);
        waitn(4);
        rd(4'h8, d); check("R4 step", d, 1);
        check("R4 no early expiry", irq, 0);
        waitn(1);
        check("R9 irq set", irq, 1);
        check("R8 no reset in irq mode", rst_req, 0);
        rd(4'h8, d); check("R4 reload", d, 5);
        waitn(7);
        check("R9 irq sticky", irq, 1);
        service();
        check("R9 irq cleared", irq, 0);
        rd(4'h8, d); check("R6 service reload", d, 5);
        wr(4'h4, 0);
    endtask

    task automatic t_reset_mode();
        logic [31:0] d;
        wr(4'h4, mk(4, 0, 0, 0, 1, 1, 0));
        waitn(3);
        check("R8 not yet", rst_req, 0);
        waitn(1);
        check("R8 pulse", rst_req, 1);
        rd(4'h8, d); check("R4 reload after reset", d, 4);
        waitn(1);
        check("R8 one cycle", rst_req, 0);
        check("R8 irq untouched", irq, 0);
        wr(4'h4, 0);
    endtask

    task automatic t_service_seq();
        logic [31:0] d;
        wr(4'h4, mk(40, 0, 0, 0, 1, 0, 0));
        waitn(5);
        service();
        rd(4'h8, d); check("R6 reload", d, 40);
        wr(4'hE, 32'h556C);
        wr(4'hE, 32'h1234);
        wr(4'hE, 32'hAA39);
        rd(4'h8, d); check("R7 cancelled", d, 37);
        wr(4'hE, 32'h0000);
        wr(4'hE, 32'hAA39);
        rd(4'h8, d); check("R7 lone key ignored", d, 35);
        wr(4'h4, 0);
    endtask

    task automatic t_prescale();
        logic [31:0] d;
        wr(4'h4, mk(2, 0, 0, 0, 1, 0, 1));
        waitn(100);
        wr(4'h4, mk(2, 0, 0, 0, 1, 0, 1));
        waitn(PSC - 1);
        rd(4'h8, d); check("R3 prescaler restart", d, 2);
        waitn(1);
        rd(4'h8, d); check("R5 one step per period", d, 1);
        waitn(PSC - 1);
        check("R5 no early irq", irq, 0);
        waitn(1);
        check("R5 expiry at 2 periods", irq, 1);
        service();
        wr(4'h4, 0);
    endtask

    task automatic t_freeze();
        logic [31:0] d;
        wr(4'h4, mk(50, 0, 0, 1, 1, 0, 0));
        dbg_freeze = 1'b1;
        waitn(6);
        rd(4'h8, d); check("R10 frozen", d, 50);
        dbg_freeze = 1'b0;
        waitn(3);
        rd(4'h8, d); check("R10 runs when input low", d, 47);
        wr(4'h4, mk(50, 0, 0, 0, 1, 0, 0));
        dbg_freeze = 1'b1;
        waitn(4);
        rd(4'h8, d); check("R10 runs when bit clear", d, 46);
        dbg_freeze = 1'b0;
        wr(4'h4, mk(5, 0, 0, 0, 0, 1, 0));
        waitn(12);
        rd(4'h8, d); check("R11 disabled holds", d, 5);
        check("R11 no expiry", {rst_req, irq}, 0);
        wr(4'h4, 0);
    endtask

    task automatic pulse_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic t_busmon();
        int seen;
        wr(4'h4, mk(0, 2, 1, 0, 0, 0, 0));
        pulse_start();
        waitn(15);
        check("R12 not yet", bus_err, 0);
        waitn(1);
        check("R12 error at 16", bus_err, 1);
        waitn(1);
        check("R12 one cycle", bus_err, 0);
        pulse_start();
        waitn(5);
        bus_ack = 1'b1; @(negedge clk); bus_ack = 1'b0;
        seen = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (bus_err) seen++; end
        check("R12 ack in time", seen, 0);
        wr(4'h4, mk(0, 0, 1, 0, 0, 0, 0));
        pulse_start();
        seen = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (bus_err) seen++; end
        check("R12 zero limit", seen, 0);
        wr(4'h4, mk(0, 1, 0, 0, 0, 0, 0));
        pulse_start();
        seen = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (bus_err) seen++; end
        check("R12 disabled", seen, 0);
        wr(4'h4, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog timeout actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        waitn(3);
        rst_n = 1'b1;
        waitn(1);
        t_reset();
        t_regs();
        t_count_irq();
        t_reset_mode();
        t_service_seq();
        t_prescale();
        t_freeze();
        t_busmon();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule